// File: doc/BRIEF.md
# Host-Fed Program Bootstrap Loader

The block runs once after reset. It loads program memory from a stream of 24-bit words that the host sends through a valid/ready receive interface. When the mode inputs select host boot, the first accepted word gives the number of program words. The second gives the program-memory address where loading begins. Each word after that is written to the next program-memory address through a single-cycle synchronous write port.

When the last word has been written, the block pulses `start_o` for one cycle and presents the load base address on `start_vec_o`, so the core can begin execution there. The host can end loading early by raising an abort flag. This flag is synchronized and then triggers the same start pulse with the same vector. After the pulse, the block stays inert until the next reset.

Top module: `boot_loader`

## Requirements
- R1: Loading is enabled only when `mode_i[2:0]` equals 3'b100. `mode_i[3]` is ignored. On any other value the block stays idle with `word_ready_o` low. The mode is only looked at while idle, so a later change has no effect.
- R2: The first word accepted (`word_valid_i && word_ready_o` at a rising edge) is taken as the payload word count.
- R3: The second word accepted is the load base address. The first payload word is written to that address, and each later word goes to the previous address plus one.
- R4: A payload word accepted in a cycle produces, in that same cycle, `mem_we_o`=1 with `mem_addr_o` set to its address and `mem_wdata_o` equal to `word_i`. `mem_we_o` is 0 in every other cycle.
- R5: The write address is 24 bits wide and wraps from 24'hFFFFFF to 24'h000000.
- R6: After the edge that accepts the last payload word, `start_o` is 1 for exactly one cycle, with `start_vec_o` equal to the base address.
- R7: A count of zero writes nothing. `start_o` pulses in the cycle after the address word is accepted.
- R8: `word_ready_o` is 1 only while the block is waiting for a header or payload word. Once the start pulse is issued, ready and write stay 0 until reset.
- R9: `abort_i` passes through a two-flop synchronizer. When it is high at edge k, `word_ready_o` falls after edge k+1, and `start_o` pulses in the cycle after edge k+2. The vector is the base address, or 0 if no address word had been received.
- R10: In the cycle where the synchronized abort is high, an offered word is not accepted and not written.
- R11: While reset is held, `word_ready_o`, `mem_we_o` and `start_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 4 | Boot mode select; host boot when bits [2:0] are 100 |
| abort_i | input | 1 | Asynchronous host flag requesting early end of loading |
| word_i | input | 24 | Received host word |
| word_valid_i | input | 1 | `word_i` holds a word |
| word_ready_o | output | 1 | Block accepts a word this cycle |
| mem_we_o | output | 1 | Program memory write enable |
| mem_addr_o | output | 24 | Program memory write address |
| mem_wdata_o | output | 24 | Program memory write data |
| start_o | output | 1 | One-cycle request to begin execution |
| start_vec_o | output | 24 | Execution start address, valid with `start_o` |

## Verification
The memory write is due in the same cycle as the handshake. The start pulse is due one cycle after the handshake that accepts the last payload word or the address word. An abort reaches the ready output two edges after it is sampled, and reaches the start pulse three edges after it is sampled.

A behavioural model in the bench advances on each rising edge with the same inputs as the design. It counts these latencies from the edges themselves. All outputs are compared against it at the falling edge, once the state has settled. Inputs change one time unit after each rising edge, so they never race the compare.

// File: rtl/boot_loader_pkg.sv
package boot_loader_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CNT,
    ST_ADDR,
    ST_LOAD,
    ST_FIRE,
    ST_DONE
  } bl_state_e;
endpackage

// File: rtl/bl_flag_sync.sv
module bl_flag_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/bl_addr_gen.sv
module bl_addr_gen #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] base_i,
  input  logic         inc_i,
  output logic [W-1:0] addr_o,
  output logic [W-1:0] base_o
);
  logic [W-1:0] addr_q, base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      base_q <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
      base_q <= base_i;
    end else if (inc_i) begin
      addr_q <= addr_q + 1'b1;  // wraps modulo 2^W
    end
  end

  assign addr_o = addr_q;
  assign base_o = base_q;

  // R3 R5
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> addr_q == $past(addr_q) + W'(1));

  // R6
  base_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> base_q == $past(base_q));
endmodule

// File: rtl/bl_word_cnt.sv
module bl_word_cnt #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] cnt_i,
  input  logic         dec_i,
  output logic         empty_o,
  output logic         last_o
);
  logic [W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (load_i) rem_q <= cnt_i;
    else if (dec_i)  rem_q <= rem_q - 1'b1;
  end

  assign empty_o = (rem_q == '0);
  assign last_o  = (rem_q == W'(1));

  // R7
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> !empty_o);
endmodule

// File: rtl/bl_ctrl.sv
module bl_ctrl
  import boot_loader_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_ok_i,
  input  logic abort_i,
  input  logic valid_i,
  input  logic empty_i,
  input  logic last_i,
  output logic ready_o,
  output logic take_cnt_o,
  output logic take_addr_o,
  output logic write_o,
  output logic start_o
);
  bl_state_e st_q, st_d;
  logic busy, acc;

  assign busy    = (st_q == ST_CNT) || (st_q == ST_ADDR) || (st_q == ST_LOAD);
  // abort wins over an arriving word
  assign ready_o = busy && !abort_i;
  assign acc     = ready_o && valid_i;

  assign take_cnt_o  = acc && (st_q == ST_CNT);
  assign take_addr_o = acc && (st_q == ST_ADDR);
  assign write_o     = acc && (st_q == ST_LOAD);
  assign start_o     = (st_q == ST_FIRE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (mode_ok_i) st_d = ST_CNT;
      ST_CNT: begin
        if (abort_i)  st_d = ST_FIRE;
        else if (acc) st_d = ST_ADDR;
      end
      ST_ADDR: begin
        if (abort_i)  st_d = ST_FIRE;
        else if (acc) st_d = empty_i ? ST_FIRE : ST_LOAD;
      end
      ST_LOAD: begin
        if (abort_i)            st_d = ST_FIRE;
        else if (acc && last_i) st_d = ST_FIRE;
      end
      ST_FIRE: st_d = ST_DONE;
      ST_DONE: st_d = ST_DONE;
      default: st_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // R6
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  // R8
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (!ready_o && !write_o));

  // R9
  abort_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && busy) |=> start_o);

  // R10
  abort_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |-> !write_o);
endmodule

// File: rtl/boot_loader.sv
module boot_loader #(
  parameter int         WORD_W    = 24,
  parameter int         MODE_W    = 4,
  parameter int         SYNC_STG  = 2,
  parameter logic [3:0] BOOT_MASK = 4'b0111,
  parameter logic [3:0] BOOT_PAT  = 4'b0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              abort_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              start_o,
  output logic [WORD_W-1:0] start_vec_o
);
  localparam logic [MODE_W-1:0] MASK_W = MODE_W'(BOOT_MASK);
  localparam logic [MODE_W-1:0] PAT_W  = MODE_W'(BOOT_PAT & BOOT_MASK);

  logic mode_ok, abort_s, empty, last;
  logic take_cnt, take_addr, write_en;
  logic [WORD_W-1:0] addr, base;

  assign mode_ok = ((mode_i & MASK_W) == PAT_W);

  bl_flag_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (abort_i),
    .q_o   (abort_s)
  );

  bl_word_cnt #(.W(WORD_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (take_cnt),
    .cnt_i  (word_i),
    .dec_i  (write_en),
    .empty_o(empty),
    .last_o (last)
  );

  bl_addr_gen #(.W(WORD_W)) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(take_addr),
    .base_i(word_i),
    .inc_i (write_en),
    .addr_o(addr),
    .base_o(base)
  );

  bl_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_ok_i  (mode_ok),
    .abort_i    (abort_s),
    .valid_i    (word_valid_i),
    .empty_i    (empty),
    .last_i     (last),
    .ready_o    (word_ready_o),
    .take_cnt_o (take_cnt),
    .take_addr_o(take_addr),
    .write_o    (write_en),
    .start_o    (start_o)
  );

  assign mem_we_o    = write_en;
  assign mem_addr_o  = addr;
  assign mem_wdata_o = word_i;
  assign start_vec_o = base;

  // R4
  we_handshake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (word_valid_i && word_ready_o));

  // R11
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!word_ready_o && !mem_we_o && !start_o));
endmodule

// File: tb/boot_loader_test.sv
module boot_loader_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode = 4'b0000;
  logic        abort = 1'b0;
  logic [23:0] word = '0;
  logic        valid = 1'b0;
  logic        ready, we, start;
  logic [23:0] maddr, mdata, vec;

  int n_run = 0, n_fail = 0, wd = 0;
  int seen_wr = 0, seen_start = 0;

  // reference model state
  int          m_ph = 0;  // 0 idle 1 cnt 2 addr 3 load 4 fire 5 done
  logic [23:0] m_cnt = '0, m_base = '0, m_addr = '0;
  logic [1:0]  m_sync = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_loader uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .abort_i(abort),
    .word_i(word), .word_valid_i(valid), .word_ready_o(ready),
    .mem_we_o(we), .mem_addr_o(maddr), .mem_wdata_o(mdata),
    .start_o(start), .start_vec_o(vec)
  );

  function automatic logic exp_ready();
    return (m_ph >= 1 && m_ph <= 3) && !m_sync[1];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = '0; m_base = '0; m_addr = '0; m_sync = '0;
    end else begin
      logic acc;
      acc = exp_ready() && valid;
      case (m_ph)
        0: if (mode[2:0] == 3'b100) m_ph = 1;
        1: if (m_sync[1]) m_ph = 4;
           else if (acc) begin m_cnt = word; m_ph = 2; end
        2: if (m_sync[1]) m_ph = 4;
           else if (acc) begin
             m_base = word; m_addr = word;
             m_ph = (m_cnt == 0) ? 4 : 3;
           end
        3: if (m_sync[1]) m_ph = 4;
           else if (acc) begin
             m_addr = m_addr + 24'd1; m_cnt = m_cnt - 24'd1;
             if (m_cnt == 0) m_ph = 4;
           end
        4: m_ph = 5;
        default: m_ph = 5;
      endcase
      m_sync = {m_sync[0], abort};
    end
  end

  task automatic chk(input logic ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic e_we;
    e_we = (m_ph == 3) && exp_ready() && valid;
    if (!rst_n) begin
      chk(!ready && !we && !start, "R11 reset outputs", {21'd0, ready, we, start}, 24'd0);
    end else begin
      chk(ready == exp_ready(), "R1/R8/R9 ready", {23'd0, ready}, {23'd0, exp_ready()});
      chk(we == e_we, "R4/R10 write enable", {23'd0, we}, {23'd0, e_we});
      if (we && e_we) begin
        chk(maddr == m_addr, "R3/R5 write address", maddr, m_addr);
        chk(mdata == word, "R4 write data", mdata, word);
      end
      chk(start == (m_ph == 4), "R6/R7/R9 start pulse", {23'd0, start}, {23'd0, m_ph == 4});
      if (start) chk(vec == m_base, "R6 start vector", vec, m_base);
      if (we) seen_wr++;
      if (start) seen_start++;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_fail++;
      $display("[TB] FAIL watchdog act=%0d exp=<100000", wd);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic restart(input logic [3:0] md);
    rst_n = 1'b0; valid = 1'b0; abort = 1'b0; mode = md;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    seen_wr = 0; seen_start = 0;
  endtask

  task automatic push(input logic [23:0] w, input int gap);
    logic hs;
    int tries;
    valid = 1'b0;
    repeat (gap) begin @(posedge clk); #1; end
    valid = 1'b1; word = w; tries = 0;
    do begin
      @(negedge clk); hs = ready;
      @(posedge clk); #1;
      tries++;
    end while (!hs && tries < 20);
    valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic tally(input string req, input int wr, input int st);
    chk(seen_wr == wr, {req, " write count"}, 24'(seen_wr), 24'(wr));
    chk(seen_start == st, {req, " start count"}, 24'(seen_start), 24'(st));
  endtask

  initial begin
    // R1: wrong mode, offered words ignored
    restart(4'b0101);
    push(24'h000003, 0);
    idle(5);
    tally("R1 bad mode", 0, 0);

    // R2 R3 R4 R6: normal load, top mode bit set, with gaps
    restart(4'b1100);
    push(24'h000003, 1);
    push(24'h000100, 0);
    push(24'hABCDEF, 2);
    mode = 4'b0000;  // R1 ignored after leaving idle
    push(24'h123456, 0);
    push(24'h654321, 1);
    push(24'h777777, 0);  // R8 extra word not taken
    idle(4);
    tally("R6 normal load", 3, 1);

    // R7: zero count
    restart(4'b0100);
    push(24'h000000, 0);
    push(24'h004000, 0);
    push(24'h111111, 0);
    idle(3);
    tally("R7 zero count", 0, 1);

    // R5: address wrap
    restart(4'b0100);
    push(24'h000004, 0);
    push(24'hFFFFFE, 0);
    for (int i = 0; i < 4; i++) push(24'h0A0000 + 24'(i), 0);
    idle(3);
    tally("R5 wrap", 4, 1);

    // R9 R10: abort mid-load with a word held on the bus
    restart(4'b0100);
    push(24'h00000A, 0);
    push(24'h000200, 0);
    push(24'h000001, 0);
    push(24'h000002, 0);
    valid = 1'b1; word = 24'h0BAD00;
    abort = 1'b1;
    idle(1);
    valid = 1'b0;
    idle(1);
    valid = 1'b1; word = 24'h0BAD01;
    idle(6);
    valid = 1'b0;
    tally("R9 abort load", 3, 1);

    // R9: abort before address, vector zero
    restart(4'b0100);
    push(24'h000005, 0);
    abort = 1'b1;
    idle(6);
    tally("R9 abort header", 0, 1);

    restart(4'b0100);
    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule